// File: doc/BRIEF.md
# PCM Highway Time-Slot Serial Port

This block is the slave side of a time-division PCM highway. An external bit clock and a frame strobe come in from the highway. In every frame, the block shifts one sample out on the serial output and captures one sample from the serial input. Each sample sits at a programmable bit position. The block runs on a fast local clock. It passes the highway clock, frame strobe and serial input through one synchronizer of equal depth, so the three stay aligned. It then acts on the detected edges of the highway clock.

The transmit and receive positions are set independently. Each position has three parts:
- a time-slot number (in units of eight bits),
- a bit offset within that slot,
- a half-clock edge choice.

Samples are either 8 bits or 16 bits wide. A 16-bit sample spans two adjacent slots. The serial output is enabled only while the programmed transmit bits are on the highway, so several ports can share one line. On the local side, a parallel transmit word is latched at frame start, and a received word is presented with a single-cycle strobe.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset is held and right after it is released, `dx_oe`, `dx`, `rx_valid` and `tx_load` are all low.
- R2: Bit slot 0 of a frame begins at the first falling edge of `pclk` that sees `fs` high after `fs` was seen low at the previous falling edge. Each later falling edge advances the slot by one. If `fs` stays high over several falling edges, the frame is not re-aligned.
- R3: The transmit start slot is 8*`tx_slot`+`tx_cslot`. The receive start slot is 8*`rx_slot`+`rx_cslot`. The two are set independently.
- R4: With `tx_pol`=0, `dx` takes the bit of slot k at the falling edge that opens slot k. With `tx_pol`=1, it takes that bit at the rising edge in the middle of slot k.
- R5: With `rx_pol`=0, the bit of slot k is sampled at the rising edge in the middle of slot k. With `rx_pol`=1, it is sampled at the falling edge that closes slot k.
- R6: With `wide16`=0, `tx_data[7:0]` is sent over 8 slots, bit 7 first. The received byte appears in `rx_data[7:0]` with its first bit in bit 7, and `rx_data[15:8]` reads zero.
- R7: With `wide16`=1, `tx_data[15:0]` is sent over 16 consecutive slots, bit 15 first. 16 received bits fill `rx_data`, with the first bit in bit 15.
- R8: `dx_oe` is high only while `dx` carries a programmed transmit bit. It is low in every other slot, and `dx` reads 0 while `dx_oe` is low.
- R9: `tx_data` is latched at the falling edge that opens slot 0. `tx_load` pulses for one cycle at that point. Changes to `tx_data` later in the frame do not affect the bits sent in that frame.
- R10: `rx_valid` pulses for exactly one cycle, once per frame, after the last bit of the receive field has been sampled. `rx_data` is valid in that cycle.
- R11: A field that runs past the frame's last slot is cut off when the next frame starts. Nothing wraps into the next frame, and a truncated receive field produces no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, much faster than `pclk` |
| rst_n | input | 1 | Active-low synchronous reset |
| pclk | input | 1 | Highway bit clock |
| fs | input | 1 | Highway frame strobe |
| dr | input | 1 | Serial data from the highway |
| dx | output | 1 | Serial data to the highway |
| dx_oe | output | 1 | Output enable for `dx` |
| tx_slot | input | TS_W | Transmit time slot |
| tx_cslot | input | 3 | Transmit bit offset within the slot |
| tx_pol | input | 1 | Transmit launch edge: 0 falling, 1 rising |
| rx_slot | input | TS_W | Receive time slot |
| rx_cslot | input | 3 | Receive bit offset within the slot |
| rx_pol | input | 1 | Receive sample edge: 0 rising, 1 falling |
| wide16 | input | 1 | 1 selects 16-bit samples, 0 selects 8-bit |
| tx_data | input | 16 | Parallel transmit sample |
| tx_load | output | 1 | One-cycle pulse when `tx_data` is latched |
| rx_data | output | 16 | Parallel received sample |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is new |

## Verification
The bench goes after the following corner cases:
- **Transmit field at slot 0 with falling-edge launch.** The first bit must come from the word being latched on that very edge. A design that read the old latched word would send the previous frame's MSB.
- **Both polarity settings.** A receive sample taken on the wrong edge shifts the captured word by one bit. A transmit launched on the wrong edge is caught when `dx` is checked mid-way between edges.
- **Long frame strobe and mid-frame change of `tx_data`.** A design that re-aligned on a level of `fs` would slide every field. A design that read `tx_data` live would send a mix of two words.
- **Short frame with fields that cross its end.** A design that wrapped the field, or strobed a partial receive word, is caught by checking the enable in the early slots of the next frame and by counting `rx_valid` pulses.

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int TS_W = 7,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pclk,
  input  logic            fs,
  input  logic            dr,
  output logic            dx,
  output logic            dx_oe,
  input  logic [TS_W-1:0] tx_slot,
  input  logic [2:0]      tx_cslot,
  input  logic            tx_pol,
  input  logic [TS_W-1:0] rx_slot,
  input  logic [2:0]      rx_cslot,
  input  logic            rx_pol,
  input  logic            wide16,
  input  logic [15:0]     tx_data,
  output logic            tx_load,
  output logic [15:0]     rx_data,
  output logic            rx_valid
);

  localparam int CNT_W = TS_W + 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC-1:0] pclk_sy, fs_sy, dr_sy;
  logic pclk_d, fs_last, in_frame;
  logic [CNT_W-1:0] cnt;
  logic [15:0] tx_word, rx_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pclk_sy <= '0;
      fs_sy   <= '0;
      dr_sy   <= '0;
      pclk_d  <= 1'b0;
    end else begin
      pclk_sy <= {pclk_sy[SYNC-2:0], pclk};
      fs_sy   <= {fs_sy[SYNC-2:0], fs};
      dr_sy   <= {dr_sy[SYNC-2:0], dr};
      pclk_d  <= pclk_sy[SYNC-1];
    end
  end

  wire pclk_s    = pclk_sy[SYNC-1];
  wire fs_s      = fs_sy[SYNC-1];
  wire dr_s      = dr_sy[SYNC-1];
  wire pclk_fall = pclk_d & ~pclk_s;
  wire pclk_rise = ~pclk_d & pclk_s;
  wire frame_start = pclk_fall & fs_s & ~fs_last;

  wire [CNT_W-1:0] cnt_next = frame_start ? '0 :
                              (cnt == CNT_MAX) ? cnt : cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      fs_last  <= 1'b0;
      in_frame <= 1'b0;
    end else if (pclk_fall) begin
      cnt     <= cnt_next;
      fs_last <= fs_s;
      if (frame_start) in_frame <= 1'b1;
    end
  end

  wire [CNT_W-1:0] fld_len  = wide16 ? CNT_W'(16) : CNT_W'(8);
  wire [CNT_W-1:0] tx_start = CNT_W'({tx_slot, 3'b000}) + CNT_W'(tx_cslot);
  wire [CNT_W-1:0] rx_start = CNT_W'({rx_slot, 3'b000}) + CNT_W'(rx_cslot);

  // transmit side
  wire             drv_edge = tx_pol ? pclk_rise : pclk_fall;
  wire [CNT_W-1:0] drv_idx  = tx_pol ? cnt : cnt_next;
  wire [15:0]      drv_word = frame_start ? tx_data : tx_word;
  wire             tx_on    = (in_frame | frame_start) &&
                              drv_idx >= tx_start && drv_idx < tx_start + fld_len;
  wire [3:0]       tx_k     = 4'(drv_idx - tx_start);
  wire [3:0]       tx_pos   = (wide16 ? 4'd15 : 4'd7) - tx_k;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_word <= '0;
      tx_load <= 1'b0;
      dx      <= 1'b0;
      dx_oe   <= 1'b0;
    end else begin
      tx_load <= frame_start;
      if (frame_start) tx_word <= tx_data;
      if (drv_edge) begin
        dx_oe <= tx_on;
        dx    <= tx_on ? drv_word[tx_pos] : 1'b0;
      end
    end
  end

  // receive side
  wire smp_edge = rx_pol ? pclk_fall : pclk_rise;
  wire rx_on    = in_frame && cnt >= rx_start && cnt < rx_start + fld_len;
  wire rx_last  = cnt == rx_start + fld_len - CNT_W'(1);
  wire [15:0] rx_next = {rx_sr[14:0], dr_s};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sr    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (smp_edge && rx_on) begin
        rx_sr <= rx_next;
        if (rx_last) begin
          rx_valid <= 1'b1;
          rx_data  <= wide16 ? rx_next : {8'h00, rx_next[7:0]};
        end
      end
    end
  end

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pclk_fall) |-> cnt == $past(cnt));
  assert_oe_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_oe != $past(dx_oe)) |-> $past(drv_edge));
  assert_rx_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !wide16) |-> rx_data[15:8] == 8'h00);
  assert_oe_framed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dx_oe |-> in_frame);
  assert_load_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (cnt == '0 && in_frame));
  assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_word != $past(tx_word)) |-> tx_load);
  assert_rxv_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: tb/pcm_slot_port_tb.sv
module pcm_slot_port_tb;
  localparam int HP = 8;

  logic clk = 0, rst_n = 0, pclk = 1, fs = 0, dr = 0;
  logic [6:0] tx_slot = 0, rx_slot = 0;
  logic [2:0] tx_cslot = 0, rx_cslot = 0;
  logic tx_pol = 0, rx_pol = 0, wide16 = 0;
  logic [15:0] tx_data = 0;
  logic dx, dx_oe, tx_load, rx_valid;
  logic [15:0] rx_data;

  int n_chk = 0, n_fail = 0;
  int rxv_cnt = 0, load_cnt = 0;
  logic [15:0] rx_got = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcm_slot_port u_dut (
    .clk(clk), .rst_n(rst_n), .pclk(pclk), .fs(fs), .dr(dr),
    .dx(dx), .dx_oe(dx_oe),
    .tx_slot(tx_slot), .tx_cslot(tx_cslot), .tx_pol(tx_pol),
    .rx_slot(rx_slot), .rx_cslot(rx_cslot), .rx_pol(rx_pol),
    .wide16(wide16), .tx_data(tx_data), .tx_load(tx_load),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(posedge clk) begin
    if (rx_valid) begin rxv_cnt++; rx_got = rx_data; end
    if (tx_load) load_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int flen();
    return wide16 ? 16 : 8;
  endfunction

  function automatic bit exp_on(input int k);
    int s = tx_slot * 8 + tx_cslot;
    return k >= s && k < s + flen();
  endfunction

  function automatic bit exp_bit(input int k, input logic [15:0] w);
    int s = tx_slot * 8 + tx_cslot;
    if (!exp_on(k)) return 1'b0;
    return w[flen() - 1 - (k - s)];
  endfunction

  function automatic bit rx_bit(input int k, input logic [15:0] w);
    int s = rx_slot * 8 + rx_cslot;
    if (k >= s && k < s + flen()) return w[flen() - 1 - (k - s)];
    return 1'b1;
  endfunction

  task automatic run_frame(input string tag, input int nbits, input int fs_hold,
                           input logic [15:0] txw, input logic [15:0] rxw,
                           input int rx_exp_n, input int mid_k, input logic [15:0] mid_v);
    int errs = 0, bad_k = -1, r0 = rxv_cnt, l0 = load_cnt;
    logic [15:0] rx_exp;
    for (int k = 0; k < nbits; k++) begin
      pclk = 0;
      if (!rx_pol) dr = rx_bit(k, rxw);
      repeat (4) @(negedge clk);
      if (tx_pol && k > 0 && (dx_oe !== exp_on(k-1) || dx !== exp_bit(k-1, txw))) begin
        errs++; if (bad_k < 0) bad_k = k - 1;
      end
      repeat (HP - 4) @(negedge clk);
      pclk = 1;
      if (rx_pol) dr = rx_bit(k, rxw);
      if (k == fs_hold - 1) fs = 0;
      if (k == nbits - 1) fs = 1;
      if (k == mid_k) tx_data = mid_v;
      repeat (4) @(negedge clk);
      if (!tx_pol && (dx_oe !== exp_on(k) || dx !== exp_bit(k, txw))) begin
        errs++; if (bad_k < 0) bad_k = k;
      end
      repeat (HP - 4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check(errs == 0, {tag, " R3/R4/R8 dx slots, first bad slot"}, bad_k, -1);
    check(load_cnt - l0 == 1, {tag, " R9 tx_load pulses"}, load_cnt - l0, 1);
    check(rxv_cnt - r0 == rx_exp_n, {tag, " R10/R11 rx_valid pulses"}, rxv_cnt - r0, rx_exp_n);
    if (rx_exp_n == 1) begin
      rx_exp = wide16 ? rxw : {8'h00, rxw[7:0]};
      check(rx_got == rx_exp, {tag, " R5/R6/R7 rx_data"}, rx_got, rx_exp);
    end
  endtask

  task automatic t_reset();
    check(dx_oe === 1'b0 && dx === 1'b0, "R1 dx/dx_oe after reset", {dx_oe, dx}, 0);
    check(rx_valid === 1'b0 && tx_load === 1'b0, "R1 strobes after reset", {rx_valid, tx_load}, 0);
    pclk = 1; fs = 1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic t_basic8();
    wide16 = 0; tx_pol = 0; rx_pol = 0;
    tx_slot = 2; tx_cslot = 0; rx_slot = 5; rx_cslot = 3;
    tx_data = 16'h12A5;
    run_frame("basic8 R2", 64, 1, 16'h12A5, 16'h003C, 1, -1, 0);
    tx_data = 16'hFF5A;
    run_frame("basic8b R6", 64, 1, 16'hFF5A, 16'h00C3, 1, -1, 0);
  endtask

  task automatic t_pol();
    wide16 = 0; tx_pol = 1; rx_pol = 1;
    tx_slot = 1; tx_cslot = 6; rx_slot = 3; rx_cslot = 2;
    tx_data = 16'h00B4;
    run_frame("pol long-fs R2 R4 R5", 64, 5, 16'h00B4, 16'h0096, 1, -1, 0);
    tx_data = 16'h0037;
    run_frame("pol2 R5", 64, 3, 16'h0037, 16'h0069, 1, -1, 0);
  endtask

  task automatic t_wide16();
    wide16 = 1; tx_pol = 0; rx_pol = 1;
    tx_slot = 0; tx_cslot = 0; rx_slot = 2; rx_cslot = 7;
    tx_data = 16'h9C35;
    run_frame("wide16 R7", 64, 1, 16'h9C35, 16'hB1E4, 1, -1, 0);
    tx_pol = 1; rx_pol = 0; tx_slot = 3; tx_cslot = 5;
    tx_data = 16'h4E17;
    run_frame("wide16b R7", 64, 2, 16'h4E17, 16'h82D9, 1, -1, 0);
  endtask

  task automatic t_latch();
    wide16 = 0; tx_pol = 0; rx_pol = 0;
    tx_slot = 4; tx_cslot = 0; rx_slot = 6; rx_cslot = 0;
    tx_data = 16'h0066;
    run_frame("latch R9", 64, 1, 16'h0066, 16'h005A, 1, 10, 16'h0099);
    run_frame("latch next R9", 64, 1, 16'h0099, 16'h00A5, 1, -1, 0);
  endtask

  task automatic t_trunc();
    wide16 = 0; tx_pol = 0; rx_pol = 0;
    tx_slot = 3; tx_cslot = 4; rx_slot = 3; rx_cslot = 6;
    tx_data = 16'h00D2;
    run_frame("trunc R11", 32, 1, 16'h00D2, 16'h00FF, 0, -1, 0);
    run_frame("trunc again R11", 32, 1, 16'h00D2, 16'h00FF, 0, -1, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic8();
    t_pol();
    t_wide16();
    t_latch();
    t_trunc();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule